// File: doc/BRIEF.md
# Associative Name Store Miss Controller

This block holds a small fully associative store of address/value lines and the state machine that runs when a lookup finds no line for its key. In normal running, every cycle takes a key into the interrogate register. On the following cycle the compare result is latched into a one-hot line-select register, which drives the hit flag and the read value. Store orders that hit overwrite the value of the selected line and mark that line modified.

When the pipeline reports a miss, the controller stalls the pipeline. It copies a one-hot ring pointer into the line-select register to choose a victim, stepping past any line reserved by a pending deferred write. If the victim is modified, the controller writes it back. It then issues a fetch for the missing address and acts on the reply, which can carry data, report that the word was deleted elsewhere, report that the other buffer kept the word, or report a translation fault. Last, it rebuilds the lookup state for the two addresses still in flight. The same write-back and restore path also evicts a line when an accumulator-destined store hits it.

Top module: `nsm_miss_ctrl`

## Requirements
- R1: After reset all lines are invalid, the pointer selects line 0, and no request or wait is raised. A lookup presented on `look_addr_i` shows its `hit_o`, `sel_line_o` and `rd_data_o` result two clock edges later.
- R2: The victim of a miss is the line named by the pointer. A completed install moves the pointer to the next line, wrapping from the last line to line 0.
- R3: If the selected line's bit is set in `pend_mask_i`, the selection rotates one line up and is tested again. A skipped line is never chosen.
- R4: A modified victim is written back with its stored address and value before any fetch is issued. The write request holds steady while `mem_wr_ready_i` is low, and the written-back line no longer hits afterwards.
- R5: Reply code 0 (data) installs the miss address with the reply data as a valid, unmodified line.
- R6: Reply code 2 (deleted elsewhere) installs the miss address at once with value zero, without using reply data.
- R7: Reply code 1 (kept elsewhere) installs nothing and leaves the pointer unchanged.
- R8: Reply code 3 (fault) raises `irq_o` for one cycle and installs nothing.
- R9: When the sequence ends, `hit_o`/`sel_line_o` first reflect the older in-flight address. One cycle later they reflect the younger in-flight address. The older key is held one settle cycle before the strobe.
- R10: `acc_evict_i` on a hit writes back that line's address and value, then leaves the line invalid.
- R11: `wait_o` is high from the cycle in which the miss or eviction is signalled until the restore completes.
- R12: `store_wr_i` on a hit while idle replaces the value of the selected line and marks it modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| look_addr_i | input | AW | Key offered for the normal lookup each cycle |
| miss_i | input | 1 | Miss detected for `miss_addr_i` |
| miss_addr_i | input | AW | Address that missed |
| acc_evict_i | input | 1 | Accumulator store hit: evict the selected line |
| store_wr_i | input | 1 | Store order writes the selected line |
| store_data_i | input | DW | Value written by a store order |
| older_addr_i | input | AW | Older in-flight address, replayed first |
| younger_addr_i | input | AW | Younger in-flight address, replayed second |
| pend_mask_i | input | N | Lines reserved by pending deferred writes |
| hit_o | output | 1 | Selected line valid |
| sel_line_o | output | N | One-hot line-select register |
| rd_data_o | output | DW | Value of the selected line |
| wait_o | output | 1 | Pipeline hold |
| mem_wr_valid_o | output | 1 | Write-back request |
| mem_wr_addr_o | output | AW | Write-back address |
| mem_wr_data_o | output | DW | Write-back value |
| mem_wr_ready_i | input | 1 | Write-back accepted |
| fetch_valid_o | output | 1 | Fetch request |
| fetch_addr_o | output | AW | Fetch address |
| fetch_ready_i | input | 1 | Fetch accepted |
| reply_valid_i | input | 1 | Reply present |
| reply_kind_i | input | 2 | 0 data, 1 kept, 2 deleted, 3 fault |
| reply_data_i | input | DW | Reply word |
| irq_o | output | 1 | Fault interrupt request pulse |

## Verification
A corrupted pointer shows at the ports on the next miss. The line presented on `sel_line_o` while the fetch is outstanding would be the wrong line, or more than one line. A lost modified bit shows as a missing write-back before that line's fetch. A valid bit left stale shows as a hit two cycles after the key for that line is presented. A fault in the restore ordering shows in the first two idle cycles after `wait_o` falls, as the wrong address's hit state.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SELECT, ST_WB, ST_FETCH, ST_WAITR,
    ST_EVICT, ST_REKEY, ST_SETTLE, ST_STROBE
  } nsm_state_e;

  localparam logic [1:0] RPL_DATA    = 2'd0;
  localparam logic [1:0] RPL_KEPT    = 2'd1;
  localparam logic [1:0] RPL_DELETED = 2'd2;
  localparam logic [1:0] RPL_FAULT   = 2'd3;
endpackage

// File: rtl/nsm_lines.sv
module nsm_lines #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] key_i,
  output logic [N-1:0]  match_o,
  input  logic [N-1:0]  sel_i,
  output logic [AW-1:0] sel_key_o,
  output logic [DW-1:0] sel_val_o,
  output logic          sel_mod_o,
  input  logic          inst_en_i,
  input  logic [AW-1:0] inst_key_i,
  input  logic [DW-1:0] inst_val_i,
  input  logic          upd_en_i,
  input  logic [DW-1:0] upd_val_i,
  input  logic          clr_mod_en_i,
  input  logic          drop_en_i
);
  logic [AW-1:0] key_q [N];
  logic [DW-1:0] val_q [N];
  logic [N-1:0]  valid_q;
  logic [N-1:0]  mod_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign match_o[i] = valid_q[i] && (key_q[i] == key_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        key_q[i]   <= '0;
        val_q[i]   <= '0;
        valid_q[i] <= 1'b0;
        mod_q[i]   <= 1'b0;
      end else if (sel_i[i]) begin
        if (inst_en_i) begin
          key_q[i]   <= inst_key_i;
          val_q[i]   <= inst_val_i;
          valid_q[i] <= 1'b1;
          mod_q[i]   <= 1'b0;
        end else if (drop_en_i) begin
          valid_q[i] <= 1'b0;
          mod_q[i]   <= 1'b0;
        end else if (upd_en_i) begin
          val_q[i] <= upd_val_i;
          mod_q[i] <= 1'b1;
        end else if (clr_mod_en_i) begin
          mod_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    sel_key_o = '0;
    sel_val_o = '0;
    sel_mod_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) begin
        sel_key_o = sel_key_o | key_q[i];
        sel_val_o = sel_val_o | val_q[i];
        sel_mod_o = sel_mod_o | mod_q[i];
      end
    end
  end

  // R5
  install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en_i |=> ((valid_q & $past(sel_i)) == $past(sel_i)) && ((mod_q & $past(sel_i)) == '0));

  // R10
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_en_i && !inst_en_i) |=> ((valid_q & $past(sel_i)) == '0));
endmodule

// File: rtl/nsm_ctrl.sv
module nsm_ctrl
  import nsm_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_i,
  input  logic [AW-1:0] miss_addr_i,
  input  logic          evict_i,
  input  logic          store_wr_i,
  input  logic [AW-1:0] look_addr_i,
  input  logic [AW-1:0] older_addr_i,
  input  logic [AW-1:0] younger_addr_i,
  input  logic [N-1:0]  pend_mask_i,
  input  logic [N-1:0]  match_i,
  input  logic          sel_mod_i,
  input  logic          mem_wr_ready_i,
  input  logic          fetch_ready_i,
  input  logic          reply_valid_i,
  input  logic [1:0]    reply_kind_i,
  output logic [AW-1:0] ireg_o,
  output logic [N-1:0]  line_sel_o,
  output logic          wait_o,
  output logic          wb_req_o,
  output logic          fetch_req_o,
  output logic          irq_o,
  output logic          inst_en_o,
  output logic          inst_zero_o,
  output logic          upd_en_o,
  output logic          clr_mod_en_o,
  output logic          drop_en_o
);
  function automatic logic [N-1:0] ring_step(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]};
  endfunction

  nsm_state_e    state_q, state_d;
  logic [N-1:0]  ptr_q, ptr_d;
  logic [N-1:0]  sel_q, sel_d;
  logic [AW-1:0] ireg_q, ireg_d;
  logic          irq_q, irq_d;

  logic sel_hit, sel_pend, take_miss, take_evict, reply_fill;

  assign sel_hit    = |sel_q;
  assign sel_pend   = |(sel_q & pend_mask_i);
  assign take_miss  = (state_q == ST_IDLE) && miss_i;
  assign take_evict = (state_q == ST_IDLE) && !miss_i && evict_i && sel_hit;
  assign reply_fill = (state_q == ST_WAITR) && reply_valid_i &&
                      ((reply_kind_i == RPL_DATA) || (reply_kind_i == RPL_DELETED));

  always_comb begin
    state_d      = state_q;
    ptr_d        = ptr_q;
    sel_d        = sel_q;
    ireg_d       = ireg_q;
    irq_d        = 1'b0;
    wb_req_o     = 1'b0;
    fetch_req_o  = 1'b0;
    inst_en_o    = 1'b0;
    inst_zero_o  = 1'b0;
    upd_en_o     = 1'b0;
    clr_mod_en_o = 1'b0;
    drop_en_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (take_miss) begin
          ireg_d  = miss_addr_i;
          sel_d   = ptr_q;
          state_d = ST_SELECT;
        end else if (take_evict) begin
          state_d = ST_EVICT;
        end else begin
          upd_en_o = store_wr_i && sel_hit;
          ireg_d   = look_addr_i;
          sel_d    = match_i;
        end
      end
      ST_SELECT: begin
        if (sel_pend) begin
          sel_d = ring_step(sel_q);
          ptr_d = ring_step(sel_q);
        end else if (sel_mod_i) begin
          state_d = ST_WB;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_WB: begin
        wb_req_o = 1'b1;
        if (mem_wr_ready_i) begin
          clr_mod_en_o = 1'b1;
          state_d      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        fetch_req_o = 1'b1;
        if (fetch_ready_i) state_d = ST_WAITR;
      end
      ST_WAITR: begin
        if (reply_valid_i) begin
          if (reply_fill) begin
            inst_en_o   = 1'b1;
            inst_zero_o = (reply_kind_i == RPL_DELETED);
            ptr_d       = ring_step(sel_q);
          end
          irq_d   = (reply_kind_i == RPL_FAULT);
          state_d = ST_REKEY;
        end
      end
      ST_EVICT: begin
        wb_req_o = 1'b1;
        if (mem_wr_ready_i) begin
          drop_en_o = 1'b1;
          state_d   = ST_REKEY;
        end
      end
      ST_REKEY: begin
        ireg_d  = older_addr_i;
        state_d = ST_SETTLE;
      end
      ST_SETTLE: state_d = ST_STROBE;
      ST_STROBE: begin
        sel_d   = match_i;
        ireg_d  = younger_addr_i;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= N'(1);
      sel_q   <= '0;
      ireg_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      sel_q   <= sel_d;
      ireg_q  <= ireg_d;
      irq_q   <= irq_d;
    end
  end

  assign ireg_o     = ireg_q;
  assign line_sel_o = sel_q;
  assign irq_o      = irq_q;
  assign wait_o     = (state_q != ST_IDLE) || take_miss || take_evict;

  // R1
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ptr_q) == 1);

  // R2
  select_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SELECT) |-> (sel_q == ptr_q));

  // R4
  fetch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> !sel_mod_i);

  // R8
  irq_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !$past(inst_en_o));
endmodule

// File: rtl/nsm_miss_ctrl.sv
module nsm_miss_ctrl #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_addr_i,
  input  logic          miss_i,
  input  logic [AW-1:0] miss_addr_i,
  input  logic          acc_evict_i,
  input  logic          store_wr_i,
  input  logic [DW-1:0] store_data_i,
  input  logic [AW-1:0] older_addr_i,
  input  logic [AW-1:0] younger_addr_i,
  input  logic [N-1:0]  pend_mask_i,
  output logic          hit_o,
  output logic [N-1:0]  sel_line_o,
  output logic [DW-1:0] rd_data_o,
  output logic          wait_o,
  output logic          mem_wr_valid_o,
  output logic [AW-1:0] mem_wr_addr_o,
  output logic [DW-1:0] mem_wr_data_o,
  input  logic          mem_wr_ready_i,
  output logic          fetch_valid_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_ready_i,
  input  logic          reply_valid_i,
  input  logic [1:0]    reply_kind_i,
  input  logic [DW-1:0] reply_data_i,
  output logic          irq_o
);
  logic [AW-1:0] ireg;
  logic [N-1:0]  line_sel, match;
  logic [AW-1:0] sel_key;
  logic [DW-1:0] sel_val;
  logic          sel_mod;
  logic          inst_en, inst_zero, upd_en, clr_mod_en, drop_en;

  nsm_ctrl #(.N(N), .AW(AW)) u_ctrl (
    .clk, .rst_n,
    .miss_i, .miss_addr_i,
    .evict_i(acc_evict_i), .store_wr_i, .look_addr_i,
    .older_addr_i, .younger_addr_i, .pend_mask_i,
    .match_i(match), .sel_mod_i(sel_mod),
    .mem_wr_ready_i, .fetch_ready_i, .reply_valid_i, .reply_kind_i,
    .ireg_o(ireg), .line_sel_o(line_sel), .wait_o,
    .wb_req_o(mem_wr_valid_o), .fetch_req_o(fetch_valid_o), .irq_o,
    .inst_en_o(inst_en), .inst_zero_o(inst_zero), .upd_en_o(upd_en),
    .clr_mod_en_o(clr_mod_en), .drop_en_o(drop_en)
  );

  nsm_lines #(.N(N), .AW(AW), .DW(DW)) u_lines (
    .clk, .rst_n,
    .key_i(ireg), .match_o(match), .sel_i(line_sel),
    .sel_key_o(sel_key), .sel_val_o(sel_val), .sel_mod_o(sel_mod),
    .inst_en_i(inst_en), .inst_key_i(ireg),
    .inst_val_i(inst_zero ? '0 : reply_data_i),
    .upd_en_i(upd_en), .upd_val_i(store_data_i),
    .clr_mod_en_i(clr_mod_en), .drop_en_i(drop_en)
  );

  assign hit_o         = |line_sel;
  assign sel_line_o    = line_sel;
  assign rd_data_o     = sel_val;
  assign mem_wr_addr_o = sel_key;
  assign mem_wr_data_o = sel_val;
  assign fetch_addr_o  = ireg;

  // R4
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));

  // R11
  wait_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_o || mem_wr_valid_o) |-> wait_o);
endmodule

// File: tb/test_nsm_miss_ctrl.sv
module test_nsm_miss_ctrl;
  localparam int N = 8, AW = 16, DW = 32;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] look_addr_i = '0, miss_addr_i = '0, older_addr_i = '0, younger_addr_i = '0;
  logic miss_i = 0, acc_evict_i = 0, store_wr_i = 0;
  logic [DW-1:0] store_data_i = '0, reply_data_i = '0;
  logic [N-1:0] pend_mask_i = '0;
  logic hit_o, wait_o, mem_wr_valid_o, fetch_valid_o, irq_o;
  logic [N-1:0] sel_line_o;
  logic [DW-1:0] rd_data_o, mem_wr_data_o;
  logic [AW-1:0] mem_wr_addr_o, fetch_addr_o;
  logic mem_wr_ready_i = 1, fetch_ready_i = 1, reply_valid_i = 0;
  logic [1:0] reply_kind_i = 0;

  nsm_miss_ctrl #(.N(N), .AW(AW), .DW(DW)) i_nsm_miss_ctrl (.*);

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); #1; endtask

  task automatic look(input logic [AW-1:0] a, output logic h, output logic [DW-1:0] d);
    @(negedge clk); look_addr_i = a;
    tick; tick;
    h = hit_o; d = rd_data_o;
  endtask

  // Drives a miss (evict=0) or an eviction (evict=1) and runs it to completion.
  task automatic run_seq(input bit evict, input logic [AW-1:0] addr,
                         input logic [AW-1:0] older, input logic [AW-1:0] younger,
                         input logic [1:0] kind, input logic [DW-1:0] data, input int stall,
                         output logic [N-1:0] victim, output bit wb_seen,
                         output logic [AW-1:0] wb_a, output logic [DW-1:0] wb_d,
                         output bit irq_seen, output bit wait_first,
                         output logic h1, output logic [N-1:0] s1, output logic h2,
                         output bit wb_moved);
    bit send, sent;
    int st;
    victim = '0; wb_seen = 0; wb_a = '0; wb_d = '0; irq_seen = 0; wb_moved = 0;
    send = 0; sent = 0; st = stall;
    @(negedge clk);
    older_addr_i = older; younger_addr_i = younger;
    if (evict) acc_evict_i = 1; else begin miss_i = 1; miss_addr_i = addr; end
    #1 wait_first = wait_o;
    @(negedge clk);
    miss_i = 0; acc_evict_i = 0;
    for (int c = 0; c < 60; c++) begin
      #1;
      if (!wait_o) break;
      reply_valid_i = 0;
      if (send) begin
        reply_valid_i = 1; reply_kind_i = kind; reply_data_i = data; send = 0;
      end
      if (irq_o) irq_seen = 1;
      if (mem_wr_valid_o) begin
        if (wb_seen && (mem_wr_addr_o !== wb_a || mem_wr_data_o !== wb_d)) wb_moved = 1;
        if (!wb_seen) begin wb_seen = 1; wb_a = mem_wr_addr_o; wb_d = mem_wr_data_o; end
        mem_wr_ready_i = (st == 0);
        if (st > 0) st--;
      end else mem_wr_ready_i = 1;
      if (fetch_valid_o && !sent) begin
        victim = sel_line_o; send = 1; sent = 1;
        if (fetch_addr_o !== addr) victim = '1;
      end
      @(negedge clk);
      if (c == 59) chk("watchdog", 1, 0);
    end
    reply_valid_i = 0; mem_wr_ready_i = 1;
    h1 = hit_o; s1 = sel_line_o;
    tick;
    h2 = hit_o;
  endtask

  logic h, h1, h2; logic [DW-1:0] d; logic [N-1:0] v, s1;
  bit wbs, irqs, wf, mv; logic [AW-1:0] wa; logic [DW-1:0] wd;

  task automatic t_reset;
    chk("R1 hit after reset", hit_o, 0);
    chk("R1 wait after reset", wait_o, 0);
    chk("R1 requests after reset", {mem_wr_valid_o, fetch_valid_o, irq_o}, 0);
    look(16'h0100, h, d);
    chk("R1 empty lookup", h, 0);
  endtask

  task automatic t_first_fill;
    run_seq(0, 16'h0100, 16'h0100, 16'h0200, 2'd0, 32'hAAAA_0001, 0, v, wbs, wa, wd, irqs, wf, h1, s1, h2, mv);
    chk("R11 wait on miss cycle", wf, 1);
    chk("R2 victim line0", v, 8'h01);
    chk("R4 no writeback clean", wbs, 0);
    chk("R9 older restored", {h1, s1}, {1'b1, 8'h01});
    chk("R9 younger restored", h2, 0);
    look(16'h0100, h, d);
    chk("R5 installed hit", h, 1);
    chk("R1 R5 installed data", d, 32'hAAAA_0001);
  endtask

  task automatic t_store;
    @(negedge clk); store_wr_i = 1; store_data_i = 32'h5555_7777;
    @(negedge clk); store_wr_i = 0; #1;
    chk("R12 store updates value", rd_data_o, 32'h5555_7777);
  endtask

  task automatic t_skip;
    pend_mask_i = 8'h02;
    run_seq(0, 16'h0300, 16'h0, 16'h0, 2'd0, 32'h3333_3333, 0, v, wbs, wa, wd, irqs, wf, h1, s1, h2, mv);
    pend_mask_i = 0;
    chk("R3 pending line skipped", v, 8'h04);
  endtask

  task automatic t_kept_fault_deleted;
    run_seq(0, 16'h0400, 16'h0, 16'h0, 2'd1, 32'h4444, 0, v, wbs, wa, wd, irqs, wf, h1, s1, h2, mv);
    chk("R7 kept victim line3", v, 8'h08);
    look(16'h0400, h, d);
    chk("R7 kept installs nothing", h, 0);
    run_seq(0, 16'h0500, 16'h0, 16'h0, 2'd3, 32'h5555, 0, v, wbs, wa, wd, irqs, wf, h1, s1, h2, mv);
    chk("R7 pointer unchanged after kept", v, 8'h08);
    chk("R8 irq raised", irqs, 1);
    chk("R8 irq is one pulse", irq_o, 0);
    look(16'h0500, h, d);
    chk("R8 fault installs nothing", h, 0);
    run_seq(0, 16'h0600, 16'h0, 16'h0, 2'd2, 32'hDEAD_BEEF, 0, v, wbs, wa, wd, irqs, wf, h1, s1, h2, mv);
    chk("R6 deleted victim line3", v, 8'h08);
    look(16'h0600, h, d);
    chk("R6 deleted installs", h, 1);
    chk("R6 deleted value zero", d, 0);
  endtask

  task automatic t_wrap;
    for (int k = 0; k < 4; k++) begin
      run_seq(0, 16'h0700 + 16'(k) * 16'h100, 16'h0, 16'h0, 2'd0, 32'(k), 0, v, wbs, wa, wd, irqs, wf, h1, s1, h2, mv);
      chk("R2 sequential victim", v, 8'h10 << k);
    end
    run_seq(0, 16'h0B00, 16'h0B00, 16'h0100, 2'd0, 32'hBBBB, 3, v, wbs, wa, wd, irqs, wf, h1, s1, h2, mv);
    chk("R2 wrap to line0", v, 8'h01);
    chk("R4 writeback seen", wbs, 1);
    chk("R4 writeback addr", wa, 16'h0100);
    chk("R4 writeback data", wd, 32'h5555_7777);
    chk("R4 writeback held while stalled", mv, 0);
    chk("R9 older new line", {h1, s1}, {1'b1, 8'h01});
    chk("R4 R9 younger evicted gone", h2, 0);
  endtask

  task automatic t_evict;
    look(16'h0300, h, d);
    chk("R10 line present before evict", h, 1);
    run_seq(1, 16'h0, 16'h0600, 16'h0300, 2'd0, 0, 0, v, wbs, wa, wd, irqs, wf, h1, s1, h2, mv);
    chk("R11 wait on evict cycle", wf, 1);
    chk("R10 evict writeback addr", wa, 16'h0300);
    chk("R10 evict writeback data", wd, 32'h3333_3333);
    chk("R9 evict restore older", {h1, s1}, {1'b1, 8'h08});
    chk("R10 evicted line gone", h2, 0);
  endtask

  initial begin
    #12 rst_n = 1;
    tick;
    t_reset;
    t_first_fill;
    t_store;
    t_skip;
    t_kept_fault_deleted;
    t_wrap;
    t_evict;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule